// File: doc/BRIEF.md
# Hybrid Dedicated/Shared Product-Term Array

This block is the combinational core of a programmable logic block. It reads a bus of input signals and produces one sum-of-products result for each output slot, plus a small set of control-term results. Each slot has a few product terms of its own, and their OR is fixed. On top of that, a pool of shared product terms passes through a programmable OR matrix. Any slot can add any subset of the pool to its sum, and a single shared term can feed several slots at once. Common logic is therefore built only once. With the default sizes a slot can sum up to 5 + 32 = 37 product terms.

Each control term is programmed to act either as an AND of its selected literals or as an OR of them. The whole personality comes from one static configuration vector. That vector is shifted in serially, one bit per clock, while a load strobe is high. Until a load has finished, every output is held at 0.

Top module: `hybrid_pterm_array`

## Requirements
- R1: After reset, `cfg_ready` is 0 and every bit of `slot_out` and `ctl_out` is 0, whatever the value of `in_sig`.
- R2: Each slot owns `N_DED` dedicated product terms. When any of them is true, that slot's output bit is 1.
- R3: Shared product term j adds to slot s exactly when OR-matrix bit `s*N_SHR + j` is 1. A single shared term may be enabled for several slots at once.
- R4: Each product term has two select bits per input i. Bit 2i selects the true literal and bit 2i+1 selects the complemented literal. The term is the AND of its selected literals. A term with no literal selected is 0, and a term that selects both literals of the same input is 0.
- R5: Each control term has 2·`N_IN` literal select bits, encoded as in R4, followed by one mode bit. Mode 0 gives the AND of the selected literals. Mode 1 gives their OR. In either mode, a control term with no literal selected is 0.
- R6: The configuration vector, LSB upward, is laid out in this order: the dedicated terms (term index `s*N_DED + k`), then the shared terms, then the OR matrix, then the control terms. Each product term is 2·`N_IN` bits wide. While `load_en` is 1, each clock shifts `cfg_bit` in at bit 0 and moves the existing bits one place toward the MSB, so the first bit sent ends up as the MSB. While `load_en` is 0, the stored vector does not change.
- R7: While `load_en` is 1, from the next clock edge onward, `cfg_ready` is 0 and all of `slot_out` and `ctl_out` are 0.
- R8: `cfg_ready` becomes 1 on the first clock edge at which `load_en` is sampled low after having been high. It stays 1 until the next load or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shifter |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Shift strobe for the configuration vector |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| in_sig | input | N_IN | Logic inputs to the array |
| slot_out | output | N_SLOT | Per-slot sum-of-products results |
| ctl_out | output | N_CT | Control-term results |
| cfg_ready | output | 1 | Configuration loaded; outputs enabled |

## Verification
The bench instantiates a reduced array and sweeps every input combination under each of many configurations. Expected outputs come from an arithmetic sum-of-products model in the bench. Three kinds of configuration are used:
- A cleared configuration shows that empty terms and empty control terms yield 0.
- A pool-only configuration enables every shared term for every slot, which tells the programmable OR path apart from the fixed one.
- Random configurations mix single literals, complemented literals, conflicting pairs and both control-term modes.

Each configuration is loaded with the inputs held at all ones. This exposes any output that is not held at 0 during the load, and shows the one-cycle delay before `cfg_ready` rises.

// File: rtl/pterm_pkg.sv
// Shared definitions for the hybrid product-term array.
// Assumes: literal select pairs are encoded true-first (bit 2i true, bit 2i+1 complement).
package pterm_pkg;
    localparam int LIT_PER_IN = 2;

    typedef enum logic {
        CT_AND = 1'b0,
        CT_OR  = 1'b1
    } ct_mode_e;
endpackage

// File: rtl/pterm_cfg_shift.sv
// Serial configuration store. Shifts cfg_bit in at bit 0 while load_en is high,
// so the first bit sent ends at the MSB, and raises cfg_valid one edge after a load ends.
// Assumes: the vector is held static while load_en is low.
module pterm_cfg_shift #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             cfg_bit,
    output logic [CFG_W-1:0] cfg_q,
    output logic             cfg_valid
);
    logic load_q;

    // Shift register, load-edge tracker and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            load_q    <= 1'b0;
            cfg_valid <= 1'b0;
        end else begin
            load_q <= load_en;
            if (load_en) begin
                cfg_q     <= {cfg_q[CFG_W-2:0], cfg_bit};
                cfg_valid <= 1'b0;
            end else if (load_q) begin
                cfg_valid <= 1'b1;
            end
        end
    end

    // R6: vector frozen outside a load
    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(cfg_q)) else $error("cfg changed without load");

    // R8: valid follows the end of a load
    a_r8_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_en) |=> cfg_valid) else $error("valid missing after load");
endmodule

// File: rtl/pterm_and.sv
// One product term: AND of the literals selected by its select bits.
// Assumes: a term with no literal selected must read 0 (unused terms stay quiet).
module pterm_and #(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0]   x,
    input  logic [2*N_IN-1:0] sel,
    output logic              hit
);
    logic [2*N_IN-1:0] lit;

    // Build true/complement literal pairs and evaluate the AND.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lit[2*i]   = x[i];
            lit[2*i+1] = ~x[i];
        end
        hit = (|sel) & (&(lit | ~sel));
    end

    // R4: an empty term never fires
    always_comb begin
        a_r4_empty_term: assert (sel != '0 || !hit) else $error("empty term fired");
    end
endmodule

// File: rtl/ctl_term.sv
// One control term: AND or OR of its selected literals, chosen by a mode bit.
// Assumes: an empty selection reads 0 in both modes.
module ctl_term
    import pterm_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0]   x,
    input  logic [2*N_IN-1:0] sel,
    input  ct_mode_e          mode,
    output logic              y
);
    logic              and_v;
    logic              or_v;
    logic [2*N_IN-1:0] lit;

    pterm_and #(.N_IN(N_IN)) and_i (.x(x), .sel(sel), .hit(and_v));

    // OR of selected literals, then pick the configured form.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lit[2*i]   = x[i];
            lit[2*i+1] = ~x[i];
        end
        or_v = |(lit & sel);
        y    = (mode == CT_OR) ? or_v : and_v;
    end

    // R5: in OR form any selected true literal drives the output
    always_comb begin
        a_r5_or_form: assert (!(mode == CT_OR && |(lit & sel)) || y)
            else $error("OR-form control term missed a literal");
    end
endmodule

// File: rtl/slot_combine.sv
// Per-slot sum: fixed OR of the dedicated terms plus the shared terms enabled
// by this slot's OR-matrix row. Gated by the enable.
// Assumes: en is low until configuration is complete.
module slot_combine #(
    parameter int N_DED = 5,
    parameter int N_SHR = 32
) (
    input  logic             en,
    input  logic [N_DED-1:0] ded,
    input  logic [N_SHR-1:0] shr,
    input  logic [N_SHR-1:0] row,
    output logic             y
);
    // Fixed OR and programmable OR merged into one sum.
    always_comb begin
        y = en & ((|ded) | (|(shr & row)));
    end

    // R2 / R3: any active contributing term must raise the slot
    always_comb begin
        a_r2_dedicated: assert (!(en && |ded) || y) else $error("dedicated term lost");
        a_r3_shared: assert (!(en && |(shr & row)) || y) else $error("shared term lost");
    end
endmodule

// File: rtl/hybrid_pterm_array.sv
// Hybrid sum-of-products array: per-slot dedicated terms with fixed OR, a shared
// term pool through a programmable OR matrix, and dual-form control terms.
// Assumes: configuration is loaded serially before outputs are used.
module hybrid_pterm_array
    import pterm_pkg::*;
#(
    parameter int N_IN   = 36,
    parameter int N_SLOT = 16,
    parameter int N_DED  = 5,
    parameter int N_SHR  = 32,
    parameter int N_CT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              cfg_bit,
    input  logic [N_IN-1:0]   in_sig,
    output logic [N_SLOT-1:0] slot_out,
    output logic [N_CT-1:0]   ctl_out,
    output logic              cfg_ready
);
    localparam int PT_W    = LIT_PER_IN * N_IN;
    localparam int N_DPT   = N_SLOT * N_DED;
    localparam int N_PT    = N_DPT + N_SHR;
    localparam int OR_BASE = N_PT * PT_W;
    localparam int OR_W    = N_SLOT * N_SHR;
    localparam int CT_BASE = OR_BASE + OR_W;
    localparam int CT_W    = PT_W + 1;
    localparam int CFG_W   = CT_BASE + N_CT * CT_W;

    logic [CFG_W-1:0]  cfg;
    logic              valid;
    logic [N_DPT-1:0]  ded_hit;
    logic [N_SHR-1:0]  shr_hit;
    logic [N_CT-1:0]   ct_raw;

    pterm_cfg_shift #(.CFG_W(CFG_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_bit(cfg_bit),
        .cfg_q(cfg), .cfg_valid(valid)
    );

    assign cfg_ready = valid;

    // Dedicated product terms, N_DED per slot.
    for (genvar p = 0; p < N_DPT; p++) begin : g_ded
        pterm_and #(.N_IN(N_IN)) pt_i (
            .x(in_sig), .sel(cfg[p*PT_W +: PT_W]), .hit(ded_hit[p])
        );
    end

    // Shared product-term pool.
    for (genvar j = 0; j < N_SHR; j++) begin : g_shr
        pterm_and #(.N_IN(N_IN)) pt_i (
            .x(in_sig), .sel(cfg[(N_DPT + j)*PT_W +: PT_W]), .hit(shr_hit[j])
        );
    end

    // Slot sums through fixed and programmable OR.
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        slot_combine #(.N_DED(N_DED), .N_SHR(N_SHR)) sum_i (
            .en(valid),
            .ded(ded_hit[s*N_DED +: N_DED]),
            .shr(shr_hit),
            .row(cfg[OR_BASE + s*N_SHR +: N_SHR]),
            .y(slot_out[s])
        );
    end

    // Control terms with per-term AND/OR mode.
    for (genvar k = 0; k < N_CT; k++) begin : g_ct
        ctl_term #(.N_IN(N_IN)) ct_i (
            .x(in_sig),
            .sel(cfg[CT_BASE + k*CT_W +: PT_W]),
            .mode(ct_mode_e'(cfg[CT_BASE + k*CT_W + PT_W])),
            .y(ct_raw[k])
        );
    end

    // Control outputs share the configuration gate.
    always_comb begin
        ctl_out = valid ? ct_raw : '0;
    end

    // R7: loading silences every output from the next edge
    a_r7_quiet_during_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (slot_out == '0 && ctl_out == '0 && !cfg_ready))
        else $error("outputs active during load");

    // R1: outputs are idle right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!cfg_ready && slot_out == '0 && ctl_out == '0))
        else $error("outputs active after reset");
endmodule

// File: tb/hybrid_pterm_array_tb_top.sv
`timescale 1ns/1ps
module hybrid_pterm_array_tb_top;
    localparam int TI  = 4;
    localparam int TS  = 3;
    localparam int TD  = 2;
    localparam int TP  = 4;
    localparam int TC  = 3;
    localparam int PTW = 2 * TI;
    localparam int ORB = (TS * TD + TP) * PTW;
    localparam int CTB = ORB + TS * TP;
    localparam int CTW = PTW + 1;
    localparam int TOT = CTB + TC * CTW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic          cfg_bit = 1'b0;
    logic [TI-1:0] in_sig = '0;
    logic [TS-1:0] slot_out;
    logic [TC-1:0] ctl_out;
    logic          cfg_ready;
    logic [TOT-1:0] cv;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    hybrid_pterm_array #(.N_IN(TI), .N_SLOT(TS), .N_DED(TD), .N_SHR(TP), .N_CT(TC)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_bit(cfg_bit),
        .in_sig(in_sig), .slot_out(slot_out), .ctl_out(ctl_out), .cfg_ready(cfg_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4 model: AND of selected literals, empty or conflicting -> 0
    function automatic logic m_and(input logic [TOT-1:0] c, input int b, input logic [TI-1:0] x);
        logic any = 1'b0;
        logic ok  = 1'b1;
        for (int i = 0; i < TI; i++) begin
            if (c[b+2*i] || c[b+2*i+1]) any = 1'b1;
            if (c[b+2*i] && !x[i]) ok = 1'b0;
            if (c[b+2*i+1] && x[i]) ok = 1'b0;
        end
        return any && ok;
    endfunction

    function automatic logic m_or(input logic [TOT-1:0] c, input int b, input logic [TI-1:0] x);
        logic r = 1'b0;
        for (int i = 0; i < TI; i++)
            if ((c[b+2*i] && x[i]) || (c[b+2*i+1] && !x[i])) r = 1'b1;
        return r;
    endfunction

    function automatic logic [TS-1:0] m_slots(input logic [TOT-1:0] c, input logic [TI-1:0] x);
        logic [TS-1:0] r = '0;
        for (int s = 0; s < TS; s++) begin
            for (int k = 0; k < TD; k++)
                if (m_and(c, (s*TD + k)*PTW, x)) r[s] = 1'b1;
            for (int j = 0; j < TP; j++)
                if (c[ORB + s*TP + j] && m_and(c, (TS*TD + j)*PTW, x)) r[s] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [TC-1:0] m_ctl(input logic [TOT-1:0] c, input logic [TI-1:0] x);
        logic [TC-1:0] r;
        for (int k = 0; k < TC; k++) begin
            int b = CTB + k*CTW;
            r[k] = c[b + PTW] ? m_or(c, b, x) : m_and(c, b, x);
        end
        return r;
    endfunction

    // R6/R7/R8: shift MSB first with inputs all ones, checking quiet outputs mid-load
    task automatic load_cfg(input logic [TOT-1:0] c);
        in_sig = '1;
        for (int b = TOT-1; b >= 0; b--) begin
            @(negedge clk);
            if (b == TOT-3) begin
                chk("R7 slots quiet in load", 32'(slot_out), 32'd0);
                chk("R7 ctl quiet in load", 32'(ctl_out), 32'd0);
                chk("R7 not ready in load", 32'(cfg_ready), 32'd0);
            end
            load_en = 1'b1;
            cfg_bit = c[b];
        end
        @(negedge clk);
        load_en = 1'b0;
        chk("R8 ready not early", 32'(cfg_ready), 32'd0);
        @(negedge clk);
        chk("R8 ready after load", 32'(cfg_ready), 32'd1);
    endtask

    // R2/R3/R4/R5: exhaustive input sweep against the model
    task automatic sweep(input logic [TOT-1:0] c, input string tag);
        for (int v = 0; v < (1 << TI); v++) begin
            in_sig = TI'(v);
            @(negedge clk);
            chk({tag, " R2 R3 slot sums"}, 32'(slot_out), 32'(m_slots(c, TI'(v))));
            chk({tag, " R5 control terms"}, 32'(ctl_out), 32'(m_ctl(c, TI'(v))));
        end
    endtask

    function automatic logic [TOT-1:0] rand_cfg();
        logic [TOT-1:0] c = '0;
        for (int p = 0; p < (TS*TD + TP); p++)
            for (int i = 0; i < TI; i++) begin
                int r = $urandom % 6;
                if (r == 1 || r == 4) c[p*PTW + 2*i]   = 1'b1;
                if (r == 2 || r == 4) c[p*PTW + 2*i+1] = 1'b1;
            end
        for (int o = 0; o < TS*TP; o++)
            c[ORB + o] = (($urandom % 3) == 0);
        for (int k = 0; k < TC; k++) begin
            for (int i = 0; i < TI; i++) begin
                int r = $urandom % 5;
                if (r == 1) c[CTB + k*CTW + 2*i]   = 1'b1;
                if (r == 2) c[CTB + k*CTW + 2*i+1] = 1'b1;
            end
            c[CTB + k*CTW + PTW] = $urandom % 2;
        end
        return c;
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        in_sig = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(cfg_ready), 32'd0);
        chk("R1 slots after reset", 32'(slot_out), 32'd0);
        chk("R1 ctl after reset", 32'(ctl_out), 32'd0);

        // R4/R5: cleared configuration -> empty terms read 0
        cv = '0;
        load_cfg(cv);
        sweep(cv, "empty");

        // R3: every shared term on input j%TI true literal, all rows enabled
        cv = '0;
        for (int j = 0; j < TP; j++) cv[(TS*TD + j)*PTW + 2*(j % TI)] = 1'b1;
        for (int o = 0; o < TS*TP; o++) cv[ORB + o] = 1'b1;
        load_cfg(cv);
        sweep(cv, "pool");
        in_sig = 4'b0100;
        @(negedge clk);
        chk("R3 one shared term feeds all slots", 32'(slot_out), 32'(3'b111));

        // R2: dedicated term of slot 1 only, complement of input 0
        cv = '0;
        cv[(1*TD + 1)*PTW + 1] = 1'b1;
        load_cfg(cv);
        in_sig = 4'b1110;
        @(negedge clk);
        chk("R2 dedicated complement literal", 32'(slot_out), 32'(3'b010));
        in_sig = 4'b0001;
        @(negedge clk);
        chk("R2 dedicated term false", 32'(slot_out), 32'd0);

        for (int n = 0; n < 40; n++) begin
            cv = rand_cfg();
            load_cfg(cv);
            sweep(cv, "random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule